// File: doc/BRIEF.md
# Externally Clocked Serial Transmitter with Optional Double Buffering

This block sends bytes on a single data line using a shift clock supplied by a remote master. A CPU-side write strobe places a byte in a holding buffer. The byte then moves into a shift register, which presents one bit per clock period on the data line. The shift clock must already be synchronized to the system clock, and it idles high. A frame is the eight shift-clock periods that begin with the first falling edge seen while the block is idle.

A mode input selects one of two buffering modes:

- **Single buffering.** The byte is taken from the buffer when a frame starts. The interrupt pulse comes after the last bit has gone out.
- **Double buffering.** The shift register is refilled from the buffer in two cases: at once, when the shift register is empty and no frame is running, or at the end of each frame. Every refill raises the interrupt and marks the buffer empty.

A frame that begins with nothing to send sets a sticky under-run flag and sends all ones. A write into a full buffer replaces the waiting byte and sets a sticky overwrite flag.

Top module: `sclk_slave_tx`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, and `tx_irq`, `urun_err` and `ovr_wr` are 0.
- R2: A frame sends 8 bits, least significant bit first. Each bit appears after a falling edge of `sclk_s` and stays steady across the following rising edge. The frame ends on the rising edge that follows the 8th falling edge.
- R3: `txd` is 1 whenever no frame is in progress.
- R4: With `dbl_buf`=0, the buffered byte is taken when a frame starts, and `buf_empty` then reads 1. `tx_irq` pulses once, right after the frame's final rising edge, and not earlier in the frame.
- R5: With `dbl_buf`=1, a byte written while no frame runs and the shift register is empty moves into the shift register on the next cycle. That transfer sets `buf_empty` to 1 and pulses `tx_irq`. No further pulse follows until the frame ends.
- R6: With `dbl_buf`=1, a byte waiting in the buffer when a frame ends is moved into the shift register. That transfer sets `buf_empty` and pulses `tx_irq`, and the next frame sends that byte.
- R7: A frame that starts with no byte available (the buffer in single mode, the shift register in double mode) sends 0xFF and sets `urun_err`.
- R8: `urun_err` and `ovr_wr` hold their value until an `err_clr` pulse clears them.
- R9: A write (`wr_en`=1) makes `buf_empty` read 0 on the following cycle.
- R10: A write while the buffer is full and not being emptied in that cycle replaces the buffered byte and sets `ovr_wr`. The newer byte is the one sent.
- R11: Each `tx_irq` event lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbl_buf | input | 1 | 0 selects single buffering, 1 selects double buffering; change it only while idle |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | FRAME_W | Byte to transmit |
| err_clr | input | 1 | Pulse that clears `urun_err` and `ovr_wr` |
| sclk_s | input | 1 | Synchronized external shift clock, idles high |
| txd | output | 1 | Serial data line |
| buf_empty | output | 1 | 1 when the holding buffer has no byte |
| tx_irq | output | 1 | One-cycle transmit interrupt |
| urun_err | output | 1 | Sticky under-run flag |
| ovr_wr | output | 1 | Sticky flag for a write into a full buffer |

## Verification
The hardest situation to reach is the frame-end refill in double mode. It needs two things at once: one byte already in the shift register and being sent, and a second byte waiting in the buffer. The bench creates this by writing a byte, letting the immediate transfer empty the buffer, and writing the next byte before the clock starts. It repeats this as a chained sweep over all 256 values, so every frame checks both the byte sent and the refill that comes with it.

// File: rtl/sclk_slave_tx.sv
module sclk_slave_tx #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dbl_buf,
  input  logic               wr_en,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic               err_clr,
  input  logic               sclk_s,
  output logic               txd,
  output logic               buf_empty,
  output logic               tx_irq,
  output logic               urun_err,
  output logic               ovr_wr
);
  localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               sclk_q, frame_on, sh_full, buf_full, irq_q, urun_q, ovr_q;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh, hold;
  logic               fall, rise, start, finish, have, xfer, take;

  assign fall   = sclk_q & ~sclk_s;
  assign rise   = ~sclk_q & sclk_s;
  assign start  = fall & ~frame_on;
  assign finish = rise & frame_on & (cnt == LAST);
  assign have   = dbl_buf ? sh_full : buf_full;
  assign xfer   = dbl_buf & buf_full & ((~frame_on & ~sh_full & ~fall) | finish);
  assign take   = xfer | (start & ~dbl_buf);

  assign txd       = frame_on ? sh[0] : 1'b1;
  assign buf_empty = ~buf_full;
  assign tx_irq    = irq_q;
  assign urun_err  = urun_q;
  assign ovr_wr    = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q   <= 1'b1;
      frame_on <= 1'b0;
      sh_full  <= 1'b0;
      buf_full <= 1'b0;
      irq_q    <= 1'b0;
      urun_q   <= 1'b0;
      ovr_q    <= 1'b0;
      cnt      <= '0;
      sh       <= '1;
      hold     <= '0;
    end else begin
      sclk_q   <= sclk_s;
      irq_q    <= 1'b0;
      buf_full <= wr_en | (buf_full & ~take);
      if (wr_en) hold <= wr_data;

      if (wr_en && buf_full && !take) ovr_q <= 1'b1;
      else if (err_clr)               ovr_q <= 1'b0;

      if (start && !have) urun_q <= 1'b1;
      else if (err_clr)   urun_q <= 1'b0;

      if (start) begin
        frame_on <= 1'b1;
        cnt      <= '0;
        sh       <= have ? (dbl_buf ? sh : hold) : '1;
      end else if (fall && frame_on) begin
        sh  <= {1'b1, sh[FRAME_W-1:1]};
        cnt <= cnt + 1'b1;
      end
      if (finish) frame_on <= 1'b0;

      if (xfer) begin
        sh      <= hold;
        sh_full <= 1'b1;
        irq_q   <= 1'b1;
      end else if (finish) begin
        sh_full <= 1'b0;
      end
      if (finish && !dbl_buf) irq_q <= 1'b1;
    end
  end
endmodule

module sclk_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic err_clr,
  input logic txd,
  input logic buf_empty,
  input logic tx_irq,
  input logic urun_err,
  input logic ovr_wr,
  input logic frame_on
);
  AST_IDLE_HIGH:     assert property (@(posedge clk) disable iff (!rst_n) !frame_on |-> txd);                 // R3
  AST_WR_FILLS:      assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !buf_empty);              // R9
  AST_URUN_AT_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(urun_err) |-> $rose(frame_on)); // R7
  AST_URUN_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) urun_err && !err_clr |=> urun_err); // R8
  AST_OVR_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) ovr_wr && !err_clr |=> ovr_wr);     // R8
  AST_OVR_ON_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_wr) |-> $past(wr_en));    // R10
  AST_IRQ_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) tx_irq |=> !tx_irq);                // R11
endmodule

bind sclk_slave_tx sclk_slave_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .err_clr(err_clr), .txd(txd),
  .buf_empty(buf_empty), .tx_irq(tx_irq), .urun_err(urun_err), .ovr_wr(ovr_wr),
  .frame_on(frame_on)
);

// File: tb/sclk_slave_tx_test.sv
module sclk_slave_tx_test;
  logic clk = 1'b0, rst_n = 1'b0, dbl_buf = 1'b0, wr_en = 1'b0, err_clr = 1'b0, sclk_s = 1'b1;
  logic [7:0] wr_data = '0;
  logic txd, buf_empty, tx_irq, urun_err, ovr_wr;
  int n_chk = 0, n_bad = 0, irq_n = 0;
  logic [7:0] rx;
  int irq_mid;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sclk_slave_tx uut (
    .clk(clk), .rst_n(rst_n), .dbl_buf(dbl_buf), .wr_en(wr_en), .wr_data(wr_data),
    .err_clr(err_clr), .sclk_s(sclk_s), .txd(txd), .buf_empty(buf_empty),
    .tx_irq(tx_irq), .urun_err(urun_err), .ovr_wr(ovr_wr)
  );

  always @(posedge clk) if (rst_n && tx_irq) irq_n <= irq_n + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  // one frame: bits sampled while sclk_s is low and again just before each rise (R2)
  task automatic frame(output logic [7:0] bits, output int irq_before);
    bit steady = 1'b1;
    bits = '0;
    irq_before = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sclk_s = 1'b0;
      idle(3);
      bits[i] = txd;
      idle(1);
      if (txd !== bits[i]) steady = 1'b0;
      if (i == 7) irq_before = irq_n;
      sclk_s = 1'b1;
      idle(3);
    end
    check(steady, "R2 bit steady", 0, 1);
  endtask

  int base;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check(txd === 1'b1, "R1 txd", txd, 1);
    check(buf_empty === 1'b1, "R1 buf_empty", buf_empty, 1);
    check({tx_irq, urun_err, ovr_wr} === 3'b000, "R1 flags", {tx_irq, urun_err, ovr_wr}, 0);

    // single buffering: every byte value
    for (int v = 0; v < 256; v++) begin
      write(8'(v));
      idle(1);
      check(buf_empty === 1'b0, "R9 single", buf_empty, 0);
      base = irq_n;
      frame(rx, irq_mid);
      check(rx === 8'(v), "R2 single data", rx, v);
      check(irq_mid == base, "R4 no early irq", irq_mid - base, 0);
      check(irq_n == base + 1, "R4 irq after frame", irq_n - base, 1);
      check(buf_empty === 1'b1, "R4 buffer consumed", buf_empty, 1);
      check(txd === 1'b1, "R3 idle high", txd, 1);
    end
    check(urun_err === 1'b0 && ovr_wr === 1'b0, "R7 no false error", {urun_err, ovr_wr}, 0);

    // single under-run
    base = irq_n;
    frame(rx, irq_mid);
    check(rx === 8'hFF, "R7 single dummy", rx, 8'hFF);
    check(urun_err === 1'b1, "R7 single flag", urun_err, 1);
    idle(10);
    check(urun_err === 1'b1, "R8 urun sticky", urun_err, 1);
    pulse_clr(); idle(1);
    check(urun_err === 1'b0, "R8 urun cleared", urun_err, 0);

    // overwrite in single mode
    write(8'h3C);
    write(8'hC3);
    idle(1);
    check(ovr_wr === 1'b1, "R10 overwrite flag", ovr_wr, 1);
    frame(rx, irq_mid);
    check(rx === 8'hC3, "R10 newer byte sent", rx, 8'hC3);
    idle(5);
    check(ovr_wr === 1'b1, "R8 ovr sticky", ovr_wr, 1);
    pulse_clr(); idle(1);
    check(ovr_wr === 1'b0, "R8 ovr cleared", ovr_wr, 0);

    // double buffering: chained sweep
    dbl_buf = 1'b1;
    idle(2);
    base = irq_n;
    write(8'h00);
    idle(2);
    check(irq_n == base + 1, "R5 immediate transfer irq", irq_n - base, 1);
    check(buf_empty === 1'b1, "R5 buffer emptied", buf_empty, 1);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] nx;
      nx = 8'((v + 1) * 37);
      if (v < 255) begin
        write(nx);
        idle(1);
        check(buf_empty === 1'b0, "R9 double", buf_empty, 0);
      end
      base = irq_n;
      frame(rx, irq_mid);
      check(rx === ((v == 0) ? 8'h00 : 8'(v * 37)), "R2 double data", rx, (v == 0) ? 0 : 8'(v * 37));
      check(irq_mid == base, "R5 no irq mid frame", irq_mid - base, 0);
      check(irq_n == base + ((v < 255) ? 1 : 0), "R6 reload irq", irq_n - base, (v < 255) ? 1 : 0);
      check(buf_empty === 1'b1, "R6 buffer empty after reload", buf_empty, 1);
      check(txd === 1'b1, "R3 idle high dbl", txd, 1);
    end
    check(urun_err === 1'b0 && ovr_wr === 1'b0, "R7 no false error dbl", {urun_err, ovr_wr}, 0);

    // double under-run
    frame(rx, irq_mid);
    check(rx === 8'hFF, "R7 double dummy", rx, 8'hFF);
    check(urun_err === 1'b1, "R7 double flag", urun_err, 1);
    pulse_clr(); idle(1);
    check(urun_err === 1'b0, "R8 cleared dbl", urun_err, 0);

    // double: refill while shift register full, overwrite of waiting byte
    write(8'h11);
    idle(2);
    write(8'h22);
    write(8'h33);
    idle(1);
    check(ovr_wr === 1'b1, "R10 double overwrite", ovr_wr, 1);
    frame(rx, irq_mid);
    check(rx === 8'h11, "R6 first byte", rx, 8'h11);
    frame(rx, irq_mid);
    check(rx === 8'h33, "R10 newer byte dbl", rx, 8'h33);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule